// File: doc/BRIEF.md
# Micro-op Expansion Stage

This block sits between an instruction decoder and an in-order issue stage. Every decoded instruction that enters is turned into one, two or three micro-ops, and exactly one micro-op leaves per cycle. Both edges use a valid/ready handshake. The first micro-op of an accepted instruction goes out in the same cycle as the instruction is accepted. Any further micro-ops are parked in a small pending queue, and the decoder is held off until that queue has drained. No sequencing ROM is needed.

Four instruction classes are covered: plain single-operation instructions, return, call through a memory operand, and pop. Return and call are split so that the stack-pointer update is a micro-op of its own and does not wait behind the memory access. Pop is split because each micro-op writes at most one register. Every micro-op carries a kind, a destination register, a source register and an instruction sequence tag. A flush input empties the pending queue and suppresses all handshakes in the cycle in which it is high.

Top module: `upx_expand`

## Requirements
- R1: A plain instruction (class code 0) produces one micro-op of kind ALU (kind code 0), with destination and source copied from the input. It leaves in the accept cycle, and the input stays ready in the next cycle.
- R2: A return (class code 1) produces three micro-ops. They are LOAD (kind 1) with destination TMP and source SP, then ALU with destination SP and source SP, then JUMP (kind 3) with destination 0 and source TMP.
- R3: A call through memory (class code 2) produces three micro-ops. They are LOAD with destination TMP and source equal to the input source, then STORE (kind 2) with destination 0 and source SP, then ALU with destination SP and source SP.
- R4: A pop (class code 3) produces two micro-ops. They are LOAD with destination equal to the input destination and source SP, then ALU with destination SP and source SP.
- R5: in_ready is low whenever the pending queue holds a micro-op or out_ready is low. With out_ready held high, a two-micro-op instruction keeps the input stalled for one cycle and a three-micro-op instruction for two cycles.
- R6: While out_ready is low, the presented micro-op is kept, unchanged and still valid, until it is taken.
- R7: While flush is high, out_valid and in_ready are both low. From the next cycle the pending queue is empty, so any remainder of a partly issued instruction is dropped.
- R8: All micro-ops of one instruction carry the same sequence tag. The tag is 0 after reset and rises by one, wrapping, for each accepted instruction. An instruction dropped by a flush still uses up its tag.
- R9: Within one instruction, the micro-ops leave in the fixed kind order LOAD, STORE, ALU, JUMP.
- R10: After reset, out_valid is low while no instruction is offered, and in_ready follows out_ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Drops the pending micro-ops and blocks both handshakes this cycle |
| in_valid | input | 1 | Decoded instruction offered |
| in_ready | output | 1 | Stage can accept an instruction |
| in_cls | input | 2 | Instruction class: 0 plain, 1 return, 2 call through memory, 3 pop |
| in_dst | input | REG_W | Destination register of the instruction |
| in_src | input | REG_W | Source register of the instruction |
| out_valid | output | 1 | Micro-op presented |
| out_ready | input | 1 | Issue stage takes the micro-op |
| out_kind | output | 2 | Micro-op kind: 0 ALU, 1 LOAD, 2 STORE, 3 JUMP |
| out_dst | output | REG_W | Micro-op destination register |
| out_src | output | REG_W | Micro-op source register |
| out_seq | output | SEQ_W | Sequence tag of the parent instruction |

## Verification
The first micro-op of an instruction is combinational from the input. The bench therefore checks it shortly after the falling edge in the same cycle in which the instruction is offered. Micro-op k of an instruction is due k cycles after the accepting edge, counting only cycles in which out_ready is high. The bench checks each one half a cycle after the preceding edge, together with in_ready. The cycle after the last micro-op must show out_valid low and in_ready high. Flush takes effect in its own cycle and clears the pending queue at the next edge, and the bench checks both points.

// File: rtl/upx_pkg.sv
package upx_pkg;

    parameter int REG_W    = 5;
    parameter int SEQ_W    = 4;
    parameter int MAX_UOPS = 3;

    localparam int CNT_W = $clog2(MAX_UOPS + 1);

    typedef enum logic [1:0] {
        K_ALU   = 2'd0,
        K_LOAD  = 2'd1,
        K_STORE = 2'd2,
        K_JUMP  = 2'd3
    } kind_e;

    typedef enum logic [1:0] {
        C_PLAIN = 2'd0,
        C_RET   = 2'd1,
        C_CALLM = 2'd2,
        C_POP   = 2'd3
    } cls_e;

    typedef struct packed {
        kind_e            kind;
        logic [REG_W-1:0] dst;
        logic [REG_W-1:0] src;
        logic [SEQ_W-1:0] seq;
    } uop_t;

    function automatic uop_t mk_uop(kind_e k, logic [REG_W-1:0] d,
                                    logic [REG_W-1:0] s, logic [SEQ_W-1:0] q);
        uop_t u;
        u.kind = k;
        u.dst  = d;
        u.src  = s;
        u.seq  = q;
        return u;
    endfunction

    // Position of a kind in the fixed issue order of one instruction
    function automatic int unsigned kind_rank(kind_e k);
        case (k)
            K_LOAD:  return 0;
            K_STORE: return 1;
            K_ALU:   return 2;
            default: return 3;
        endcase
    endfunction

endpackage

// File: rtl/upx_cracker.sv
module upx_cracker
    import upx_pkg::*;
#(
    parameter int SP_REG  = 31,
    parameter int TMP_REG = 30
) (
    input  cls_e                        cls,
    input  logic [REG_W-1:0]            dst,
    input  logic [REG_W-1:0]            src,
    input  logic [SEQ_W-1:0]            seq,
    output uop_t [MAX_UOPS-1:0]         uops,
    output logic [CNT_W-1:0]            n_uops
);

    localparam logic [REG_W-1:0] SP  = REG_W'(SP_REG);
    localparam logic [REG_W-1:0] TMP = REG_W'(TMP_REG);
    localparam logic [REG_W-1:0] ZR  = '0;

    always_comb begin
        for (int i = 0; i < MAX_UOPS; i++) begin
            uops[i] = mk_uop(K_ALU, ZR, ZR, seq);
        end
        n_uops = CNT_W'(1);
        case (cls)
            C_PLAIN: begin
                uops[0] = mk_uop(K_ALU, dst, src, seq);
            end
            C_RET: begin
                uops[0] = mk_uop(K_LOAD, TMP, SP,  seq);
                uops[1] = mk_uop(K_ALU,  SP,  SP,  seq);
                uops[2] = mk_uop(K_JUMP, ZR,  TMP, seq);
                n_uops  = CNT_W'(3);
            end
            C_CALLM: begin
                uops[0] = mk_uop(K_LOAD,  TMP, src, seq);
                uops[1] = mk_uop(K_STORE, ZR,  SP,  seq);
                uops[2] = mk_uop(K_ALU,   SP,  SP,  seq);
                n_uops  = CNT_W'(3);
            end
            default: begin
                uops[0] = mk_uop(K_LOAD, dst, SP, seq);
                uops[1] = mk_uop(K_ALU,  SP,  SP, seq);
                n_uops  = CNT_W'(2);
            end
        endcase
    end

endmodule

// File: rtl/upx_pend_q.sv
module upx_pend_q
    import upx_pkg::*;
#(
    parameter int DEPTH = MAX_UOPS - 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 flush,
    input  logic                 push,
    input  logic [CNT_W-1:0]     push_n,
    input  uop_t [DEPTH-1:0]     push_data,
    input  logic                 pop,
    output uop_t                 head,
    output logic                 busy
);

    uop_t [DEPTH-1:0]  q;
    logic [CNT_W-1:0]  cnt;

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            cnt <= '0;
            q   <= '0;
        end else if (push) begin
            q   <= push_data;
            cnt <= push_n;
        end else if (pop) begin
            for (int i = 0; i < DEPTH - 1; i++) begin
                q[i] <= q[i+1];
            end
            cnt <= cnt - CNT_W'(1);
        end
    end

    assign head = q[0];
    assign busy = (cnt != '0);

endmodule

// File: rtl/upx_seq_ctr.sv
module upx_seq_ctr
    import upx_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             step,
    output logic [SEQ_W-1:0] seq
);

    always_ff @(posedge clk) begin
        if (rst) begin
            seq <= '0;
        end else if (step) begin
            seq <= seq + SEQ_W'(1);
        end
    end

endmodule

// File: rtl/upx_expand.sv
module upx_expand
    import upx_pkg::*;
#(
    parameter int SP_REG  = 31,
    parameter int TMP_REG = 30
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [1:0]       in_cls,
    input  logic [REG_W-1:0] in_dst,
    input  logic [REG_W-1:0] in_src,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [1:0]       out_kind,
    output logic [REG_W-1:0] out_dst,
    output logic [REG_W-1:0] out_src,
    output logic [SEQ_W-1:0] out_seq
);

    localparam int DEPTH = MAX_UOPS - 1;

    uop_t [MAX_UOPS-1:0] cracked;
    logic [CNT_W-1:0]    n_uops;
    logic [SEQ_W-1:0]    seq_now;
    uop_t                head;
    uop_t                sel;
    logic                pend_busy;
    logic                accept;
    logic                push;
    logic                pop;

    upx_seq_ctr u_seq (
        .clk  (clk),
        .rst  (rst),
        .step (accept),
        .seq  (seq_now)
    );

    upx_cracker #(
        .SP_REG  (SP_REG),
        .TMP_REG (TMP_REG)
    ) u_crack (
        .cls    (cls_e'(in_cls)),
        .dst    (in_dst),
        .src    (in_src),
        .seq    (seq_now),
        .uops   (cracked),
        .n_uops (n_uops)
    );

    upx_pend_q #(
        .DEPTH (DEPTH)
    ) u_pend (
        .clk       (clk),
        .rst       (rst),
        .flush     (flush),
        .push      (push),
        .push_n    (n_uops - CNT_W'(1)),
        .push_data (cracked[MAX_UOPS-1:1]),
        .pop       (pop),
        .head      (head),
        .busy      (pend_busy)
    );

    always_comb begin
        in_ready  = !flush && !pend_busy && out_ready;
        accept    = in_valid && in_ready;
        push      = accept && (n_uops > CNT_W'(1));
        pop       = pend_busy && out_ready && !flush;
        out_valid = !flush && (pend_busy || in_valid);
        sel       = pend_busy ? head : cracked[0];
    end

    assign out_kind = sel.kind;
    assign out_dst  = sel.dst;
    assign out_src  = sel.src;
    assign out_seq  = sel.seq;

endmodule

// File: rtl/upx_expand_chk.sv
module upx_expand_chk
    import upx_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             flush,
    input logic             in_valid,
    input logic             in_ready,
    input logic [1:0]       in_cls,
    input logic             out_valid,
    input logic             out_ready,
    input logic [1:0]       out_kind,
    input logic [REG_W-1:0] out_dst,
    input logic [REG_W-1:0] out_src,
    input logic [SEQ_W-1:0] out_seq,
    input logic             pend_busy
);

    logic             fire;
    logic             last_ok;
    logic [SEQ_W-1:0] last_seq;
    int unsigned      last_rank;

    assign fire = out_valid && out_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            last_ok   <= 1'b0;
            last_seq  <= '0;
            last_rank <= 0;
        end else if (fire) begin
            last_ok   <= 1'b1;
            last_seq  <= out_seq;
            last_rank <= kind_rank(kind_e'(out_kind));
        end
    end

    AST_FLUSH_QUIET: assert property (@(posedge clk) disable iff (rst)
        flush |-> (!out_valid && !in_ready)); // R7

    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (rst)
        flush |=> (out_valid == (in_valid && !flush))); // R7

    AST_STALL_AFTER_SPLIT: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready && in_cls != 2'd0) |=> !in_ready); // R5

    AST_PLAIN_NO_STALL: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready && in_cls == 2'd0) |=> (in_ready == (out_ready && !flush))); // R1

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready && pend_busy) |=>
        (flush || (out_valid && $stable(out_kind) && $stable(out_dst)
                   && $stable(out_src) && $stable(out_seq)))); // R6

    AST_UOP_ORDER: assert property (@(posedge clk) disable iff (rst)
        (fire && last_ok && out_seq == last_seq) |->
        (kind_rank(kind_e'(out_kind)) > last_rank)); // R9

endmodule

bind upx_expand upx_expand_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .flush     (flush),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_cls    (in_cls),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_kind  (out_kind),
    .out_dst   (out_dst),
    .out_src   (out_src),
    .out_seq   (out_seq),
    .pend_busy (pend_busy)
);

// File: tb/upx_expand_tb.sv
module upx_expand_tb;

    localparam int RW  = 5;
    localparam int SW  = 4;
    localparam int SP  = 31;
    localparam int TMP = 30;

    logic          clk = 1'b0;
    logic          rst;
    logic          flush;
    logic          in_valid;
    logic          in_ready;
    logic [1:0]    in_cls;
    logic [RW-1:0] in_dst;
    logic [RW-1:0] in_src;
    logic          out_valid;
    logic          out_ready;
    logic [1:0]    out_kind;
    logic [RW-1:0] out_dst;
    logic [RW-1:0] out_src;
    logic [SW-1:0] out_seq;

    int checks = 0;
    int errors = 0;
    int seq_exp = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    upx_expand #(.SP_REG(SP), .TMP_REG(TMP)) u_dut (
        .clk       (clk),
        .rst       (rst),
        .flush     (flush),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_cls    (in_cls),
        .in_dst    (in_dst),
        .in_src    (in_src),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_kind  (out_kind),
        .out_dst   (out_dst),
        .out_src   (out_src),
        .out_seq   (out_seq)
    );

    task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int n_of(int cls);
        case (cls)
            0:       return 1;
            3:       return 2;
            default: return 3;
        endcase
    endfunction

    function automatic string req_of(int cls);
        case (cls)
            0:       return "R1";
            1:       return "R2";
            2:       return "R3";
            default: return "R4";
        endcase
    endfunction

    // Packed expectation {kind, dst, src, seq} for micro-op k
    function automatic logic [31:0] exp_uop(int cls, int d, int s, int k, int q);
        int kd = 0, dd = 0, ss = 0;
        case (cls)
            0: begin kd = 0; dd = d; ss = s; end
            1: case (k)
                   0: begin kd = 1; dd = TMP; ss = SP;  end
                   1: begin kd = 0; dd = SP;  ss = SP;  end
                   default: begin kd = 3; dd = 0; ss = TMP; end
               endcase
            2: case (k)
                   0: begin kd = 1; dd = TMP; ss = s;  end
                   1: begin kd = 2; dd = 0;   ss = SP; end
                   default: begin kd = 0; dd = SP; ss = SP; end
               endcase
            default: case (k)
                   0: begin kd = 1; dd = d;  ss = SP; end
                   default: begin kd = 0; dd = SP; ss = SP; end
               endcase
        endcase
        return 32'({2'(kd), RW'(dd), RW'(s == s ? ss : ss), SW'(q)});
    endfunction

    function automatic logic [31:0] act_uop();
        return 32'({out_kind, out_dst, out_src, out_seq});
    endfunction

    task automatic send(int cls, int d, int s, bit stall);
        int n = n_of(cls);
        string rq = req_of(cls);
        @(negedge clk);
        in_valid  = 1'b1;
        in_cls    = 2'(cls);
        in_dst    = RW'(d);
        in_src    = RW'(s);
        out_ready = !stall;
        if (stall) begin
            #1;
            chk(!in_ready, "R5 ready low when out_ready low", 32'(in_ready), 0);
            chk(out_valid && act_uop() == exp_uop(cls, d, s, 0, seq_exp),
                "R6 first uop shown while blocked", act_uop(), exp_uop(cls, d, s, 0, seq_exp));
            @(negedge clk);
            out_ready = 1'b1;
        end
        #1;
        chk(in_ready, "R5 ready with empty queue", 32'(in_ready), 1);
        chk(out_valid && act_uop() == exp_uop(cls, d, s, 0, seq_exp),
            {rq, " R8 first uop"}, act_uop(), exp_uop(cls, d, s, 0, seq_exp));
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        for (int k = 1; k < n; k++) begin
            if (stall && k == 1) begin
                out_ready = 1'b0;
                #1;
                chk(out_valid && act_uop() == exp_uop(cls, d, s, k, seq_exp),
                    "R6 pending uop held", act_uop(), exp_uop(cls, d, s, k, seq_exp));
                @(negedge clk);
                #1;
                chk(out_valid && act_uop() == exp_uop(cls, d, s, k, seq_exp),
                    "R6 pending uop still held", act_uop(), exp_uop(cls, d, s, k, seq_exp));
                @(negedge clk);
                out_ready = 1'b1;
            end
            #1;
            chk(!in_ready, "R5 stalled while pending", 32'(in_ready), 0);
            chk(out_valid && act_uop() == exp_uop(cls, d, s, k, seq_exp),
                {rq, " R8 R9 later uop"}, act_uop(), exp_uop(cls, d, s, k, seq_exp));
            @(posedge clk);
            @(negedge clk);
        end
        #1;
        chk(!out_valid && in_ready, "R5 queue drained",
            32'({out_valid, in_ready}), 32'b01);
        seq_exp = (seq_exp + 1) % (1 << SW);
    endtask

    initial begin
        rst = 1'b1; flush = 1'b0; in_valid = 1'b0; out_ready = 1'b1;
        in_cls = '0; in_dst = '0; in_src = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        #1;
        chk(!out_valid && in_ready, "R10 reset state", 32'({out_valid, in_ready}), 32'b01);
        rst = 1'b0;
        @(negedge clk);
        out_ready = 1'b0;
        #1;
        chk(!out_valid && !in_ready, "R10 ready follows out_ready",
            32'({out_valid, in_ready}), 32'b00);
        out_ready = 1'b1;

        // Sweep of classes and operands, with and without output stalls
        for (int cls = 0; cls < 4; cls++) begin
            for (int d = 0; d < 32; d += 5) begin
                for (int s = 0; s < 4; s++) begin
                    send(cls, d, s, ((d + s + cls) % 3) != 0);
                end
            end
        end

        // Back-to-back plain instructions: no stall cycles between them (R1)
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            in_valid = 1'b1; in_cls = 2'd0; in_dst = RW'(i + 3); in_src = RW'(i);
            #1;
            chk(in_ready && act_uop() == exp_uop(0, i + 3, i, 0, seq_exp),
                "R1 R8 back-to-back plain", act_uop(), exp_uop(0, i + 3, i, 0, seq_exp));
            seq_exp = (seq_exp + 1) % (1 << SW);
        end
        @(negedge clk);
        in_valid = 1'b0;

        // Flush after the first uop of a return drops the rest (R7, R8)
        send_partial_flush();

        // Flush with an instruction offered: not accepted, tag not consumed
        @(negedge clk);
        in_valid = 1'b1; in_cls = 2'd3; in_dst = 5'd7; in_src = 5'd2; flush = 1'b1;
        #1;
        chk(!out_valid && !in_ready, "R7 offered instruction blocked by flush",
            32'({out_valid, in_ready}), 0);
        @(negedge clk);
        flush = 1'b0;
        in_valid = 1'b0;
        send(3, 7, 2, 1'b0);
        send(0, 9, 1, 1'b0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    task automatic send_partial_flush();
        @(negedge clk);
        in_valid = 1'b1; in_cls = 2'd1; in_dst = 5'd4; in_src = 5'd6;
        #1;
        chk(in_ready && act_uop() == exp_uop(1, 4, 6, 0, seq_exp),
            "R2 return first uop before flush", act_uop(), exp_uop(1, 4, 6, 0, seq_exp));
        @(negedge clk);
        in_valid = 1'b0;
        flush = 1'b1;
        #1;
        chk(!out_valid && !in_ready, "R7 quiet during flush",
            32'({out_valid, in_ready}), 0);
        @(negedge clk);
        flush = 1'b0;
        #1;
        chk(!out_valid && in_ready, "R7 pending dropped",
            32'({out_valid, in_ready}), 32'b01);
        seq_exp = (seq_exp + 1) % (1 << SW);
        send(2, 0, 3, 1'b0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule